// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is the serial chain of boundary cells that sits between a device's core logic and its pins. Each cell owns one signal path: the core drives the cell's parallel input, and the cell drives the pin through its parallel output. A test access controller elsewhere supplies the test clock and four controls: capture, shift, update and test mode. The chain takes one serial input and gives one serial output.

Each cell has a shift stage and a separate update latch. The shift stage is loaded on the rising test-clock edge, either from the core value (capture) or from its upstream neighbour (shift). The update latch copies the shift stage on the falling edge. A per-cell output selector passes the core value straight through when test mode is low. When test mode is high, it drives the pin from the update latch instead. Shifting a new vector therefore never disturbs the value being applied to the pins.

When test mode is low, the chain can sample live traffic and preload a first vector while the device keeps working. When test mode is high, the core is cut off from the pins and the pins show the latched vector. The reset state is transparent, and the latches are cleared.

Top module: `bscan_chain`

## Requirements
- R1: While trst_n is low, scan_out is 0. pin_out equals core_in when test_mode is low, and is all zeros when test_mode is high.
- R2: With test_mode low, pin_out[i] equals core_in[i] in the same cycle, whatever capture_en, shift_en, update_en and scan_in do.
- R3: With test_mode high, pin_out[i] equals the update latch of cell i. Cell 0 is the cell nearest scan_in.
- R4: On a rising edge with shift_en high and capture_en low, cell 0 loads scan_in and cell i loads cell i-1. scan_out always shows the shift stage of cell CHAIN_LEN-1. A vector v sent most-significant bit first leaves v[i] in cell i after CHAIN_LEN edges.
- R5: On a rising edge with capture_en high, every shift stage i loads core_in[i]. Capture wins over shift when both are high.
- R6: On a falling edge with update_en high, every update latch loads its cell's shift stage. At all other times the latches hold, so shifting leaves pin_out unchanged in test mode.
- R7: On a rising edge with capture_en and shift_en both low, the shift stages hold their values.
- R8: Pulling trst_n low clears the shift stages and update latches at once, without waiting for a clock. The internal reset is released on the second rising edge after trst_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| capture_en | input | 1 | Load core values into the shift stages on the rising edge |
| shift_en | input | 1 | Advance the chain one cell on the rising edge |
| update_en | input | 1 | Copy the shift stages into the update latches on the falling edge |
| test_mode | input | 1 | 1: pins driven from the latches; 0: transparent |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from the last cell |
| core_in | input | CHAIN_LEN | Parallel inputs from the core |
| pin_out | output | CHAIN_LEN | Parallel outputs toward the pins |

## Verification
pin_out is combinational in core_in and test_mode, so the bench checks it in the same cycle the inputs change. An update issued at a falling edge shows on the pins half a cycle later. A capture or shift shows on scan_out after the next rising edge, so in the following sampled cycle. The driver sets the inputs 5 ns after a rising edge and pushes the expected pins and serial bit, computed from these rules. The monitor pops and compares them 5 ns after the falling edge, once both of those edges have passed and before the next rising edge acts.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  // Control bundle shared by every cell of the chain.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic test;
  } bs_ctrl_t;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic     tck,
  input  logic     rst_n,
  input  bs_ctrl_t ctrl,
  input  logic     par_in,
  input  logic     ser_in,
  output logic     ser_out,
  output logic     par_out
);
  logic stage_q, stage_d;
  logic hold_q, hold_d;

  // Input side: capture has priority over shift, otherwise hold.
  always_comb begin
    stage_d = stage_q;
    if (ctrl.capture)    stage_d = par_in;
    else if (ctrl.shift) stage_d = ser_in;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) stage_q <= 1'b0;
    else        stage_q <= stage_d;
  end

  // Update latch, loaded on the falling edge.
  always_comb begin
    hold_d = hold_q;
    if (ctrl.update) hold_d = stage_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  // Output side: normal path or latched test value.
  assign par_out = ctrl.test ? hold_q : par_in;
  assign ser_out = stage_q;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int CHAIN_LEN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 capture_en,
  input  logic                 shift_en,
  input  logic                 update_en,
  input  logic                 test_mode,
  input  logic                 scan_in,
  output logic                 scan_out,
  input  logic [CHAIN_LEN-1:0] core_in,
  output logic [CHAIN_LEN-1:0] pin_out
);
  localparam int LAST = CHAIN_LEN - 1;

  logic                 rst_n_sync;
  bs_ctrl_t             ctrl;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] ser_feed;

  bscan_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n_sync)
  );

  always_comb begin
    ctrl.capture = capture_en;
    ctrl.shift   = shift_en;
    ctrl.update  = update_en;
    ctrl.test    = test_mode;
  end

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign ser_feed[i] = scan_in;
    end else begin : g_body
      assign ser_feed[i] = chain_q[i-1];
    end

    bscan_cell u_cell (
      .tck     (tck),
      .rst_n   (rst_n_sync),
      .ctrl    (ctrl),
      .par_in  (core_in[i]),
      .ser_in  (ser_feed[i]),
      .ser_out (chain_q[i]),
      .par_out (pin_out[i])
    );
  end

  assign scan_out = chain_q[LAST];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N = 8
) (
  input logic         tck,
  input logic         trst_n,
  input logic         rst_n_sync,
  input logic         capture_en,
  input logic         shift_en,
  input logic         update_en,
  input logic         test_mode,
  input logic         scan_in,
  input logic [N-1:0] core_in,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] chain_q
);
  // R2: transparent path
  a_r2_transparent: assert property (@(posedge tck) disable iff (!trst_n)
    !test_mode |-> pin_out == core_in);

  // R3 / R6: latched pins only move on an update
  a_r6_pins_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (test_mode && $past(test_mode) && $past(trst_n) && !update_en) |-> $stable(pin_out));

  // R6: after an update the pins show the shift stages
  a_r6_update_copy: assert property (@(posedge tck) disable iff (!rst_n_sync)
    (test_mode && update_en) |-> pin_out == chain_q);

  // R4: shift moves the chain by one cell
  a_r4_shift: assert property (@(posedge tck) disable iff (!rst_n_sync)
    (shift_en && !capture_en) |=> chain_q == {$past(chain_q[N-2:0]), $past(scan_in)});

  // R5: capture loads core values
  a_r5_capture: assert property (@(posedge tck) disable iff (!rst_n_sync)
    capture_en |=> chain_q == $past(core_in));

  // R7: idle holds
  a_r7_hold: assert property (@(posedge tck) disable iff (!rst_n_sync)
    (!capture_en && !shift_en) |=> $stable(chain_q));

  // R1 / R8: latches are clear while reset is held
  a_r8_reset_clear: assert property (@(posedge tck)
    (!trst_n && test_mode) |-> pin_out == '0);
endmodule

bind bscan_chain bscan_chain_chk #(.N(CHAIN_LEN)) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .rst_n_sync (rst_n_sync),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .update_en  (update_en),
  .test_mode  (test_mode),
  .scan_in    (scan_in),
  .core_in    (core_in),
  .pin_out    (pin_out),
  .chain_q    (chain_q)
);

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int N = 8;

  logic         tck = 1'b0;
  logic         trst_n, capture_en, shift_en, update_en, test_mode, scan_in;
  logic         scan_out;
  logic [N-1:0] core_in, pin_out;

  bscan_chain #(.CHAIN_LEN(N)) u0 (
    .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .test_mode(test_mode), .scan_in(scan_in),
    .scan_out(scan_out), .core_in(core_in), .pin_out(pin_out)
  );

  always #10 tck = ~tck;  // 50 MHz

  typedef struct {
    logic [N-1:0] pins;
    logic         so;
    string        req;
  } exp_t;

  exp_t         sb[$];
  int           n_checks = 0;
  int           n_errors = 0;
  bit           done = 0;
  logic [N-1:0] m_stage = '0;
  logic [N-1:0] m_hold  = '0;

  // Driver: one test-clock cycle of stimulus plus its expectation.
  task automatic step(input logic cap, input logic sh, input logic upd,
                      input logic tm, input logic si, input logic [N-1:0] core,
                      input logic rst_low, input string req);
    exp_t e;
    @(posedge tck);
    #5;
    capture_en = cap; shift_en = sh; update_en = upd; test_mode = tm;
    scan_in = si; core_in = core; trst_n = !rst_low;
    if (rst_low) begin
      m_stage = '0;
      m_hold  = '0;
    end else if (upd) begin
      m_hold = m_stage;             // falling edge of this cycle
    end
    e.pins = tm ? m_hold : core;
    e.so   = m_stage[N-1];
    e.req  = req;
    sb.push_back(e);
    if (!rst_low) begin             // rising edge closing this cycle
      if (cap)     m_stage = core;
      else if (sh) m_stage = {m_stage[N-2:0], si};
    end
  endtask

  task automatic idle(input int cycles, input logic tm, input string req);
    for (int k = 0; k < cycles; k++) step(0, 0, 0, tm, 0, 8'h5A ^ k[7:0], 0, req);
  endtask

  // Monitor: compares after the falling edge, before the next rising edge.
  initial begin
    forever begin
      @(negedge tck);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (pin_out !== e.pins) begin
          n_errors++;
          $display("FAIL %s pin_out actual=%h expected=%h", e.req, pin_out, e.pins);
        end
        n_checks++;
        if (scan_out !== e.so) begin
          n_errors++;
          $display("FAIL %s scan_out actual=%b expected=%b", e.req, scan_out, e.so);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] vec;
    trst_n = 1; capture_en = 0; shift_en = 0; update_en = 0;
    test_mode = 0; scan_in = 0; core_in = '0;
    #1 trst_n = 0;

    // R1: reset state, both output modes
    step(0, 0, 0, 0, 0, 8'hC3, 1, "R1");
    step(1, 1, 1, 1, 1, 8'hC3, 1, "R1");
    step(0, 0, 0, 0, 0, 8'h96, 1, "R1");
    idle(3, 0, "R8");

    // R2: transparent while shifting and updating
    for (int k = 0; k < 6; k++)
      step(0, 1, 1, 0, k[0], 8'h11 * k[7:0], 0, "R2");

    // R5 then R4: capture a core pattern and shift it out, loading a vector
    vec = 8'h3C;
    step(1, 0, 0, 0, 0, 8'hA5, 0, "R5");
    for (int k = N - 1; k >= 0; k--) step(0, 1, 0, 0, vec[k], 8'h0F, 0, "R4");
    idle(1, 0, "R7");

    // R6 / R3: update and drive the pins from the latches
    step(0, 0, 1, 1, 0, 8'hFF, 0, "R6");
    step(0, 0, 0, 1, 0, 8'h00, 0, "R3");
    for (int k = 0; k < N; k++) step(0, 1, 0, 1, 1, 8'hE7, 0, "R6");
    step(0, 0, 1, 1, 0, 8'h00, 0, "R6");
    step(0, 0, 0, 1, 0, 8'h00, 0, "R3");

    // R5: capture wins over shift
    step(1, 1, 0, 1, 1, 8'h69, 0, "R5");
    step(0, 0, 0, 1, 0, 8'h00, 0, "R5");

    // R7: no enables, chain holds while core toggles
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, ~(8'h33 << k), 0, "R7");
    step(0, 0, 1, 1, 0, 8'h00, 0, "R7");

    // R8: asynchronous reset mid-run clears the latches at once
    step(0, 0, 0, 1, 0, 8'h00, 1, "R8");
    step(0, 0, 0, 1, 0, 8'h00, 1, "R8");
    idle(3, 1, "R8");
    step(1, 0, 0, 1, 0, 8'hD2, 0, "R8");
    step(0, 0, 1, 1, 0, 8'h00, 0, "R8");
    step(0, 0, 0, 1, 0, 8'h00, 0, "R3");

    repeat (3) @(posedge tck);
    finish_run();
  end
endmodule